// File: doc/BRIEF.md
# Fractional-N Divide Ratio Modulator

This block produces the feedback divide count for a fractional-N frequency synthesizer. A 32-bit unsigned ratio in 12.20 fixed-point form (12 integer bits above 20 fraction bits) is held in the block. On every comparison-cycle update, a first-order delta-sigma accumulator adds the 20-bit fraction to its running sum. The carry out of that sum picks the integer part plus one for that cycle. Without a carry, the plain integer part is used. The share of cycles that use the higher count therefore sets the fraction, to a resolution of 2^-20 (about 0.954 ppm). The largest multiplier is just under 4096.

A new ratio is loaded with a strobe and applies at the next update. Loading it clears the accumulator, so the new average starts at once. Two examples of the encoding: a ratio of exactly 256 is 0x10000000, and 1.2288 is 0x0013A92A. A ratio whose integer part is zero is refused. The old ratio stays in force and an error flag is raised.

A programmable counter is included. It divides a fast clock enable (standing in for the oscillator) by the chosen count and gives a one-cycle pulse at each terminal count.

Top module: `fracn_ratio_mod`

## Requirements
- R1: After synchronous reset, `div_val` is 1 (the reset ratio is 1.0, encoded 0x00100000), `ratio_err` is 0 and `fb_pulse` is 0.
- R2: An update (`upd_en` high, no accepted load in the same cycle) sets `div_val`, one cycle later, to the integer part (bits 31:20) plus the carry out of the 20-bit sum of accumulator and fraction (bits 19:0).
- R3: Counted from a load, the sum of the first N values of `div_val` equals N times the integer part plus floor(N times fraction / 2^20).
- R4: A load that is accepted clears the accumulator. The sequence after a reload is the same as the sequence after the first load of that ratio.
- R5: A load whose integer part is zero is refused. The previous ratio and the accumulator phase carry on unchanged, and `ratio_err` reads 1 from the next cycle.
- R6: A load that is accepted sets `ratio_err` to 0 from the next cycle.
- R7: `div_val` changes only in the cycle after an update.
- R8: With `clk_en_vco` held high, `fb_pulse` fires once every `div_val` cycles, and each pulse is one cycle wide.
- R9: `fb_pulse` is 0 in every cycle that follows a cycle in which `clk_en_vco` was low.
- R10: The ratio 0xFFFFFFFF yields 4095 and then 4096 on the first two updates, with no overflow of the 13-bit `div_val`.
- R11: A ratio with a zero fraction yields exactly its integer part on every update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_in | input | 32 | Ratio in 12.20 unsigned fixed point |
| ratio_ld | input | 1 | Strobe that loads `ratio_in` |
| upd_en | input | 1 | One pulse per comparison cycle; advances the modulator |
| clk_en_vco | input | 1 | Fast clock enable counted by the feedback divider |
| div_val | output | 13 | Integer divide count for the current cycle |
| ratio_err | output | 1 | Last load was refused (zero integer part) |
| fb_pulse | output | 1 | One-cycle pulse at each terminal count of the divider |

## Verification
Some properties are checked by assertions on every cycle. `div_val` stays put except after an update, and an update moves it to either the integer part or the integer part plus one. An accepted load leaves the accumulator at zero. A refused load leaves the held ratio untouched and sets the flag. No divider pulse follows an idle enable cycle. Other behaviour only the directed scenarios can show. These are the exact carry pattern of each update, the long-run average over a thousand updates, the repeat of the sequence after a reload, the extreme ratio at the top of the range, and the pulse spacing of the divider against the chosen count.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
    localparam int INT_W   = 12;
    localparam int FRAC_W  = 20;
    localparam int RATIO_W = INT_W + FRAC_W;
    localparam int DIV_W   = INT_W + 1;

    typedef struct packed {
        logic [INT_W-1:0]  ipart;
        logic [FRAC_W-1:0] fpart;
    } ratio_t;

    function automatic logic ratio_legal(ratio_t r);
        return r.ipart != '0;
    endfunction

    function automatic logic [DIV_W-1:0] widen_int(ratio_t r);
        return {1'b0, r.ipart};
    endfunction
endpackage

// File: rtl/fracn_ratio_hold.sv
module fracn_ratio_hold
    import fracn_pkg::*;
#(
    parameter ratio_t RST_RATIO = 32'h0010_0000
) (
    input  logic   clk,
    input  logic   rst,
    input  ratio_t ld_ratio,
    input  logic   ld_stb,
    output ratio_t cur_ratio,
    output logic   accept,
    output logic   err
);
    assign accept = ld_stb && ratio_legal(ld_ratio);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_ratio <= RST_RATIO;
            err       <= 1'b0;
        end else if (ld_stb) begin
            if (ratio_legal(ld_ratio)) begin
                cur_ratio <= ld_ratio;
            end
            err <= !ratio_legal(ld_ratio);
        end
    end

    AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (ld_stb && ld_ratio.ipart == '0) |=> ($stable(cur_ratio) && err)); // R5

    AST_ACCEPT_CLEARS_ERR: assert property (@(posedge clk) disable iff (rst)
        accept |=> !err); // R6
endmodule

// File: rtl/fracn_dsm_acc.sv
module fracn_dsm_acc
    import fracn_pkg::*;
#(
    parameter ratio_t RST_RATIO = 32'h0010_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             upd,
    input  ratio_t           cur_ratio,
    output logic [DIV_W-1:0] div_val
);
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;

    assign sum = {1'b0, acc} + {1'b0, cur_ratio.fpart};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            div_val <= widen_int(RST_RATIO);
        end else if (clr) begin
            acc <= '0;
        end else if (upd) begin
            acc     <= sum[FRAC_W-1:0];
            div_val <= widen_int(cur_ratio) + DIV_W'(sum[FRAC_W]);
        end
    end

    AST_DIV_STABLE: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(div_val)); // R7

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
        (upd && !clr) |=> ((div_val == $past(widen_int(cur_ratio))) ||
                           (div_val == $past(widen_int(cur_ratio)) + 1'b1))); // R2

    AST_CLEAR_ACC: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc == '0)); // R4
endmodule

// File: rtl/fracn_fb_div.sv
module fracn_fb_div
    import fracn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vco_en,
    input  logic [DIV_W-1:0] div_in,
    output logic             pulse
);
    logic [DIV_W-1:0] cnt;
    logic             term;

    assign term = (cnt <= DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= DIV_W'(1);
            pulse <= 1'b0;
        end else if (vco_en) begin
            pulse <= term;
            cnt   <= term ? div_in : cnt - 1'b1;
        end else begin
            pulse <= 1'b0;
        end
    end

    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        !vco_en |=> !pulse); // R9
endmodule

// File: rtl/fracn_ratio_mod.sv
module fracn_ratio_mod
    import fracn_pkg::*;
#(
    parameter logic [RATIO_W-1:0] RST_RATIO = 32'h0010_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               ratio_ld,
    input  logic               upd_en,
    input  logic               clk_en_vco,
    output logic [DIV_W-1:0]   div_val,
    output logic               ratio_err,
    output logic               fb_pulse
);
    ratio_t cur_ratio;
    logic   accept;

    fracn_ratio_hold #(.RST_RATIO(RST_RATIO)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .ld_ratio  (ratio_t'(ratio_in)),
        .ld_stb    (ratio_ld),
        .cur_ratio (cur_ratio),
        .accept    (accept),
        .err       (ratio_err)
    );

    fracn_dsm_acc #(.RST_RATIO(RST_RATIO)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept),
        .upd       (upd_en),
        .cur_ratio (cur_ratio),
        .div_val   (div_val)
    );

    fracn_fb_div u_div (
        .clk    (clk),
        .rst    (rst),
        .vco_en (clk_en_vco),
        .div_in (div_val),
        .pulse  (fb_pulse)
    );
endmodule

// File: tb/fracn_ratio_mod_bench.sv
module fracn_ratio_mod_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ratio_in = '0;
    logic        ratio_ld = 1'b0;
    logic        upd_en = 1'b0;
    logic        clk_en_vco = 1'b0;
    logic [12:0] div_val;
    logic        ratio_err;
    logic        fb_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fracn_ratio_mod u_fracn_ratio_mod (
        .clk(clk), .rst(rst), .ratio_in(ratio_in), .ratio_ld(ratio_ld),
        .upd_en(upd_en), .clk_en_vco(clk_en_vco), .div_val(div_val),
        .ratio_err(ratio_err), .fb_pulse(fb_pulse)
    );

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load(logic [31:0] r);
        ratio_in = r;
        ratio_ld = 1'b1;
        tick();
        ratio_ld = 1'b0;
    endtask

    task automatic upd();
        upd_en = 1'b1;
        tick();
        upd_en = 1'b0;
    endtask

    function automatic longint exp_div(logic [31:0] r, longint k);
        longint ip = longint'(r[31:20]);
        longint fp = longint'(r[19:0]);
        return ip + ((k * fp) >> 20) - (((k - 1) * fp) >> 20);
    endfunction

    task automatic t_reset();
        chk("R1 div", div_val, 1);
        chk("R1 err", ratio_err, 0);
        chk("R1 pulse", fb_pulse, 0);
    endtask

    task automatic t_average(logic [31:0] r, int n);
        longint sum = 0;
        int bad = 0;
        load(r);
        for (int k = 1; k <= n; k++) begin
            upd();
            if (longint'(div_val) != exp_div(r, k)) bad++;
            sum += longint'(div_val);
        end
        chk("R2 per-update mismatches", bad, 0);
        chk("R3 sum", sum, longint'(n) * longint'(r[31:20]) + ((longint'(n) * longint'(r[19:0])) >> 20));
    endtask

    task automatic t_reload(logic [31:0] r);
        int bad = 0;
        load(r);
        for (int k = 1; k <= 7; k++) upd();
        load(r);
        for (int k = 1; k <= 16; k++) begin
            upd();
            if (longint'(div_val) != exp_div(r, k)) bad++;
        end
        chk("R4 restart mismatches", bad, 0);
    endtask

    task automatic t_zero(logic [31:0] r);
        load(r);
        for (int k = 1; k <= 3; k++) upd();
        load(32'h0001_2345);
        chk("R5 err set", ratio_err, 1);
        for (int k = 4; k <= 6; k++) begin
            upd();
            chk("R5 old ratio kept", div_val, exp_div(r, k));
        end
        load(32'h0020_0000);
        chk("R6 err cleared", ratio_err, 0);
        upd();
        chk("R6 new ratio", div_val, 2);
    endtask

    task automatic t_max();
        load(32'hFFFF_FFFF);
        upd();
        chk("R10 first", div_val, 4095);
        upd();
        chk("R10 second", div_val, 4096);
    endtask

    task automatic t_int_only();
        int bad = 0;
        load(32'h1000_0000);
        for (int k = 1; k <= 20; k++) begin
            upd();
            if (div_val != 13'd256) bad++;
        end
        chk("R11 int-only mismatches", bad, 0);
        for (int k = 0; k < 5; k++) tick();
        chk("R7 idle stable", div_val, 256);
        load(32'h0013_A92A);
        chk("R7 load without update", div_val, 256);
    endtask

    task automatic t_fbdiv();
        int last = -1;
        int bad = 0;
        int pulses = 0;
        load(32'h0050_0000);
        upd();
        chk("R8 div setup", div_val, 5);
        clk_en_vco = 1'b1;
        for (int c = 0; c < 60; c++) begin
            tick();
            if (fb_pulse) begin
                if (last >= 0 && (c - last) != 5) bad++;
                last = c;
                pulses++;
            end
        end
        chk("R8 spacing errors", bad, 0);
        chk("R8 pulse count", pulses >= 11, 1);
        clk_en_vco = 1'b0;
        bad = 0;
        for (int c = 0; c < 12; c++) begin
            tick();
            if (fb_pulse) bad++;
        end
        chk("R9 idle pulses", bad, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_average(32'h0013_A92A, 1024);
        t_average(32'h0028_0001, 256);
        t_reload(32'h0013_A92A);
        t_zero(32'h0013_A92A);
        t_max();
        t_int_only();
        t_fbdiv();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule